// File: doc/BRIEF.md
# I2C Target Interface with 7-bit, 10-bit and Broadcast Addressing

This block is the target side of a two-wire serial bus. It watches the bus clock and data lines through a synchronizer running on a fast system clock. It works out whether a transfer is meant for it, and it answers by pulling the data line low through an open-drain enable. A transfer can reach it in three ways: its own 7-bit address, its own 10-bit address (sent as a header byte and then a low-address byte), or the broadcast address. Any other reserved address in the map is refused.

Bytes written by the controller come out on a byte-wide strobe interface, and each one is acknowledged. During a read, the block takes the byte to send from its transmit input and shifts it out MSB first. It changes the data line only while the bus clock is low. A few low address bits come from input pins. These pins are captured once after reset and again only when a broadcast reload or reset command arrives. A START or STOP at any point drops whatever partial byte is in progress.

Top module: `i2c_target_core`

## Requirements
- R1: After reset the data line is released (sda_drive_low = 0) and rx_valid, tx_taken and gc_reset are all 0.
- R2: The first byte after a START is read MSB first, and its bit 0 gives the direction (1 = read, 0 = write). When the upper seven bits equal the target's own 7-bit address, the target drives SDA low from the falling SCL edge after the eighth bit until the falling edge that ends the ninth clock.
- R3: Every byte written after a matching write address is acknowledged. It is presented on rx_data together with a one-cycle rx_valid pulse, and that pulse coincides with the start of the acknowledge.
- R4: A first byte that matches nothing is not acknowledged. The target then leaves SDA released for the rest of that transfer and delivers no data.
- R5: These first bytes are never acknowledged, even if the configured address equals one of them: addresses 0000001 to 0000111 in either direction, 11111xx in either direction, and 0000000 with the read bit (the start byte).
- R6: After a matching read address, the target captures tx_data, pulses tx_taken for one cycle and drives the byte MSB first. SDA changes only while SCL is low.
- R7: In a read, a low SDA on the ninth clock makes the target load and send the next byte. A high SDA makes it release SDA until the next START or STOP.
- R8: The target acknowledges any write header 11110xx0. It acknowledges the following byte only when xx equals bits 9:8 and the byte equals bits 7:0 of its own 10-bit address. Writes then behave as in R3.
- R9: A read header 11110xx1 is acknowledged only when xx matches and the same target has completed a full 10-bit write selection since the last STOP. The read then proceeds as in R6. With no such selection, the header is refused.
- R10: A write to address 0000000 is acknowledged. A following command 0x06 is acknowledged, pulses gc_reset once and reloads the address pins. Command 0x04 is acknowledged and only reloads the pins. Any other command is not acknowledged.
- R11: addr_pins replace the low PIN_W bits of both own addresses. They are sampled once after reset and again only on a broadcast reload, so later pin changes have no effect until then.
- R12: A STOP or START in the middle of a byte discards the partial byte. Nothing is delivered, and a STOP leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins | input | PIN_W | Low address bits supplied from pins |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_data | input | 8 | Next byte to send during a read |
| tx_taken | output | 1 | One-cycle strobe when tx_data is captured |
| gc_reset | output | 1 | One-cycle strobe on the broadcast reset command |

## Verification
A wrong internal state in this block shows up at sda_drive_low within one SCL low phase. A misread address or a bad reserved-address decode gives a wrong acknowledge level on the ninth clock of the first byte. A shift or bit-count slip shows up as a wrong data bit in the next read slot, or as a strobe that is missing or misplaced. Stale 10-bit selection or address-pin state only shows in a later transaction, so the sequence goes on to re-address the target after each broadcast command and after each STOP.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] BITS_PER_BYTE = 4'd8;

  localparam logic [BYTE_W-1:0] GC_CMD_RESET  = 8'h06;
  localparam logic [BYTE_W-1:0] GC_CMD_RELOAD = 8'h04;
  localparam logic [4:0]        HDR10_TAG     = 5'b11110;
  localparam logic [4:0]        RSVD_HI_TAG   = 5'b11111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_HOLD
  } eng_state_t;

  typedef enum logic [1:0] {
    BK_ADDR, BK_ADDR10, BK_GCCMD, BK_DATA
  } byte_kind_t;

  typedef enum logic [2:0] {
    AC_NONE, AC_OWN7, AC_GCALL, AC_HDR10, AC_RSVD
  } addr_class_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  // idle bus is high, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2ct_addr_class.sv
module i2ct_addr_class
  import i2ct_pkg::*;
(
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [6:0]        own7,
  output addr_class_t       cls
);
  logic [6:0] a7;
  logic       rd;

  assign a7 = first_byte[7:1];
  assign rd = first_byte[0];

  // reserved checks come before the own-address compare
  always_comb begin
    if (a7 == 7'd0 && !rd)              cls = AC_GCALL;
    else if (a7[6:3] == 4'd0)           cls = AC_RSVD;
    else if (a7[6:2] == RSVD_HI_TAG)    cls = AC_RSVD;
    else if (a7[6:2] == HDR10_TAG)      cls = AC_HDR10;
    else if (a7 == own7)                cls = AC_OWN7;
    else                                cls = AC_NONE;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        own7,
  input  logic [9:0]        own10,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_low,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_taken,
  output logic              gc_reset,
  output logic              reload
);
  eng_state_t        state_q, state_n, after_q, after_n;
  byte_kind_t        kind_q, kind_n;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_n;
  logic [BYTE_W-1:0] shreg_q, shreg_n, txsh_q, txsh_n, rxd_q, rxd_n;
  logic drive_q, drive_n, hi_ok_q, hi_ok_n, tsel_q, tsel_n, mack_q, mack_n;
  logic rxv_q, rxv_n, txt_q, txt_n, gcr_q, gcr_n, rld_q, rld_n;
  logic ack_go, hi_match;
  addr_class_t cls;

  i2ct_addr_class u_cls (.first_byte(shreg_q), .own7(own7), .cls(cls));

  assign hi_match = (shreg_q[2:1] == own10[9:8]);

  always_comb begin
    state_n  = state_q;   after_n = after_q;   kind_n = kind_q;
    bitcnt_n = bitcnt_q;  shreg_n = shreg_q;   txsh_n = txsh_q;
    rxd_n    = rxd_q;     drive_n = drive_q;   hi_ok_n = hi_ok_q;
    tsel_n   = tsel_q;    mack_n  = mack_q;
    rxv_n = 1'b0; txt_n = 1'b0; gcr_n = 1'b0; rld_n = 1'b0;
    ack_go = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE; drive_n = 1'b0; tsel_n = 1'b0;
    end else if (start_det) begin
      state_n = ST_RX; kind_n = BK_ADDR; bitcnt_n = '0; drive_n = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_n  = {shreg_q[BYTE_W-2:0], sda_lvl};
            bitcnt_n = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == BITS_PER_BYTE) begin
            after_n = ST_RX;
            case (kind_q)
              BK_ADDR: begin
                case (cls)
                  AC_OWN7: begin
                    ack_go = 1'b1; kind_n = BK_DATA;
                    after_n = shreg_q[0] ? ST_TX : ST_RX;
                  end
                  AC_GCALL: begin ack_go = 1'b1; kind_n = BK_GCCMD; end
                  AC_HDR10: begin
                    if (!shreg_q[0]) begin
                      ack_go = 1'b1; kind_n = BK_ADDR10; hi_ok_n = hi_match;
                    end else if (tsel_q && hi_match) begin
                      ack_go = 1'b1; kind_n = BK_DATA; after_n = ST_TX;
                    end
                  end
                  default: ack_go = 1'b0;
                endcase
              end
              BK_ADDR10: begin
                if (hi_ok_q && shreg_q == own10[7:0]) begin
                  ack_go = 1'b1; kind_n = BK_DATA; tsel_n = 1'b1;
                end
              end
              BK_GCCMD: begin
                after_n = ST_HOLD;
                if (shreg_q == GC_CMD_RESET) begin
                  ack_go = 1'b1; gcr_n = 1'b1; rld_n = 1'b1;
                end else if (shreg_q == GC_CMD_RELOAD) begin
                  ack_go = 1'b1; rld_n = 1'b1;
                end
              end
              default: begin
                ack_go = 1'b1; rxv_n = 1'b1; rxd_n = shreg_q;
              end
            endcase
            state_n = ack_go ? ST_ACK : ST_HOLD;
            drive_n = ack_go;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            drive_n = 1'b0; bitcnt_n = '0; state_n = after_q;
            if (after_q == ST_TX) begin
              txsh_n = tx_data; drive_n = ~tx_data[BYTE_W-1]; txt_n = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_n = bitcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt_q == BITS_PER_BYTE) begin
              drive_n = 1'b0; state_n = ST_TXACK;
            end else begin
              txsh_n  = {txsh_q[BYTE_W-2:0], 1'b0};
              drive_n = ~txsh_q[BYTE_W-2];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n = ST_TX; bitcnt_n = '0; txsh_n = tx_data;
              drive_n = ~tx_data[BYTE_W-1]; txt_n = 1'b1;
            end else begin
              state_n = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  after_q <= ST_IDLE;  kind_q <= BK_ADDR;
      bitcnt_q <= '0;      shreg_q <= '0;       txsh_q <= '0;
      rxd_q <= '0;         drive_q <= 1'b0;     hi_ok_q <= 1'b0;
      tsel_q <= 1'b0;      mack_q <= 1'b0;
      rxv_q <= 1'b0; txt_q <= 1'b0; gcr_q <= 1'b0; rld_q <= 1'b0;
    end else begin
      state_q <= state_n;  after_q <= after_n;  kind_q <= kind_n;
      bitcnt_q <= bitcnt_n; shreg_q <= shreg_n; txsh_q <= txsh_n;
      rxd_q <= rxd_n;      drive_q <= drive_n;  hi_ok_q <= hi_ok_n;
      tsel_q <= tsel_n;    mack_q <= mack_n;
      rxv_q <= rxv_n; txt_q <= txt_n; gcr_q <= gcr_n; rld_q <= rld_n;
    end
  end

  assign sda_low  = drive_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
  assign tx_taken = txt_q;
  assign gc_reset = gcr_q;
  assign reload   = rld_q;
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2ct_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h3A,
  parameter logic [9:0] ADDR10      = 10'h2B6,
  parameter int         PIN_W       = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_pins,
  output logic              sda_drive_low,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_taken,
  output logic              gc_reset
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic reload, pin_ok_q, pin_load;
  logic [PIN_W-1:0] pin_q;
  logic [6:0] own7;
  logic [9:0] own10;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  // pins are captured on the first cycle after reset and on each reload
  assign pin_load = !pin_ok_q || reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '0;
      pin_ok_q <= 1'b0;
    end else if (pin_load) begin
      pin_q    <= addr_pins;
      pin_ok_q <= 1'b1;
    end
  end

  assign own7  = {ADDR7[6:PIN_W], pin_q};
  assign own10 = {ADDR10[9:PIN_W], pin_q};

  i2ct_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own7(own7), .own10(own10), .tx_data(tx_data),
    .sda_low(sda_drive_low), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_taken(tx_taken), .gc_reset(gc_reset), .reload(reload)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic stop_det,
  input logic sda_drive_low,
  input logic rx_valid,
  input logic tx_taken,
  input logic gc_reset
);
  // R6
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !scl_lvl);

  // R3
  rx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sda_drive_low);

  // R10
  gc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |-> sda_drive_low);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_drive_low && !rx_valid));

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, tx_taken, gc_reset}));

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |=> !tx_taken);
endmodule

bind i2c_target_core i2ct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_det(stop_det),
  .sda_drive_low(sda_drive_low), .rx_valid(rx_valid),
  .tx_taken(tx_taken), .gc_reset(gc_reset)
);

// File: tb/i2c_target_core_tb_top.sv
module i2c_target_core_tb_top;
  logic clk, rst_n, scl_ctl, sda_ctl;
  logic [1:0] addr_pins;
  logic [7:0] tx_data, rx_data;
  logic sda_drive_low, rx_valid, tx_taken, gc_reset, sda_bus;
  int n_chk, n_fail, gc_seen;
  logic exp_drive, cmp_on, done;
  string cur_req;
  logic [7:0] rx_exp[$];
  logic [7:0] tx_q[$];

  assign sda_bus = sda_ctl & ~sda_drive_low;

  i2c_target_core dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ctl), .sda_i(sda_bus),
    .addr_pins(addr_pins), .sda_drive_low(sda_drive_low), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_data(tx_data), .tx_taken(tx_taken),
    .gc_reset(gc_reset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic fail(string req, int act, int exp);
    n_fail++;
    $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) fail(req, act, exp);
  endtask

  // every-clock comparison of the data-line drive against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      n_chk++;
      if (sda_drive_low !== exp_drive) fail({cur_req, " drive"}, sda_drive_low, exp_drive);
    end
    if (rst_n && rx_valid && !done) begin
      n_chk++;
      if (rx_exp.size() == 0) fail("R3 unexpected rx", rx_data, 0);
      else begin
        if (rx_data !== rx_exp[0]) fail("R3 rx_data", rx_data, rx_exp[0]);
        void'(rx_exp.pop_front());
      end
    end
    if (rst_n && tx_taken && !done) begin
      n_chk++;
      if (tx_q.size() == 0) fail("R6 unexpected tx_taken", 1, 0);
      else void'(tx_q.pop_front());
      tx_data = (tx_q.size() > 0) ? tx_q[0] : 8'hFF;
    end
    if (rst_n && gc_reset) gc_seen++;
  end

  task automatic push_tx(logic [7:0] b);
    tx_q.push_back(b);
    tx_data = tx_q[0];
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL period; entered just after SCL went low
  task automatic slot(input logic v, input logic ed, output logic seen);
    wait_n(6); exp_drive = ed; cmp_on = 1'b1; sda_ctl = v;
    wait_n(6); scl_ctl = 1'b1;
    wait_n(6); seen = sda_bus;
    wait_n(6); scl_ctl = 1'b0; cmp_on = 1'b0;
  endtask

  task automatic start_idle();
    exp_drive = 1'b0; cmp_on = 1'b1; sda_ctl = 1'b0;
    wait_n(12); scl_ctl = 1'b0; cmp_on = 1'b0;
  endtask

  task automatic rstart();
    wait_n(6); exp_drive = 1'b0; cmp_on = 1'b1; sda_ctl = 1'b1;
    wait_n(6); scl_ctl = 1'b1;
    wait_n(6); sda_ctl = 1'b0;
    wait_n(6); scl_ctl = 1'b0; cmp_on = 1'b0;
  endtask

  task automatic stop();
    wait_n(6); exp_drive = 1'b0; cmp_on = 1'b1; sda_ctl = 1'b0;
    wait_n(6); scl_ctl = 1'b1;
    wait_n(6); sda_ctl = 1'b1;
    wait_n(12);
  endtask

  task automatic write_byte(logic [7:0] b, logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, s);
    slot(1'b1, ack, s);
    check({cur_req, " ack level"}, s, !ack);
  endtask

  task automatic read_byte(logic [7:0] b, logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, !b[i], s);
      check({cur_req, " read bit"}, s, b[i]);
    end
    slot(!mack, 1'b0, s);
  endtask

  task automatic partial_bits(logic [7:0] b, int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) slot(b[i], 1'b0, s);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fail("watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; gc_seen = 0;
    cmp_on = 1'b0; exp_drive = 1'b0; cur_req = "R1";
    scl_ctl = 1'b1; sda_ctl = 1'b1; addr_pins = 2'b10; tx_data = 8'hFF;
    rst_n = 1'b0;
    wait_n(5);
    // R1 reset state
    check("R1 drive", sda_drive_low, 0);
    check("R1 strobes", {rx_valid, tx_taken, gc_reset}, 0);
    rst_n = 1'b1;
    wait_n(5);
    check("R1 drive after release", sda_drive_low, 0);
    check("R1 strobes after release", {rx_valid, tx_taken, gc_reset}, 0);

    // R2 R3: 7-bit write, own address 0x3A
    cur_req = "R2";
    start_idle(); write_byte(8'h74, 1'b1);
    cur_req = "R3";
    rx_exp.push_back(8'hA5); write_byte(8'hA5, 1'b1);
    rx_exp.push_back(8'h3C); write_byte(8'h3C, 1'b1);
    stop();

    // R6 R7: read two bytes, ACK then NACK
    cur_req = "R6";
    push_tx(8'h96); push_tx(8'h5A);
    start_idle(); write_byte(8'h75, 1'b1);
    read_byte(8'h96, 1'b1);
    cur_req = "R7";
    read_byte(8'h5A, 1'b0);
    write_byte(8'h00, 1'b0);
    stop();

    // R4: foreign address, following bytes ignored
    cur_req = "R4";
    start_idle(); write_byte(8'hA0, 1'b0); write_byte(8'h12, 1'b0); stop();

    // R5: reserved first bytes
    cur_req = "R5";
    start_idle(); write_byte(8'h02, 1'b0); stop();
    start_idle(); write_byte(8'h0F, 1'b0); stop();
    start_idle(); write_byte(8'hF8, 1'b0); stop();
    start_idle(); write_byte(8'hFB, 1'b0); stop();
    start_idle(); write_byte(8'h01, 1'b0); stop();

    // R8: 10-bit write to 0x2B6
    cur_req = "R8";
    start_idle(); write_byte(8'hF4, 1'b1); write_byte(8'hB6, 1'b1);
    rx_exp.push_back(8'h11); write_byte(8'h11, 1'b1); stop();
    start_idle(); write_byte(8'hF4, 1'b1); write_byte(8'hB7, 1'b0); stop();
    start_idle(); write_byte(8'hF0, 1'b1); write_byte(8'hB6, 1'b0); stop();

    // R9: 10-bit read by repeated start, and refused without selection
    cur_req = "R9";
    start_idle(); write_byte(8'hF5, 1'b0); stop();
    push_tx(8'hC3);
    start_idle(); write_byte(8'hF4, 1'b1); write_byte(8'hB6, 1'b1);
    rstart(); write_byte(8'hF5, 1'b1); read_byte(8'hC3, 1'b0); stop();

    // R12: STOP and START in the middle of a byte
    cur_req = "R12";
    start_idle(); write_byte(8'h74, 1'b1); partial_bits(8'hE7, 4); stop();
    start_idle(); write_byte(8'h74, 1'b1); partial_bits(8'h18, 3);
    rstart(); write_byte(8'h74, 1'b1);
    rx_exp.push_back(8'h7E); write_byte(8'h7E, 1'b1); stop();
    check("R12 no partial byte delivered", rx_exp.size(), 0);

    // R11: pins ignored until reload
    cur_req = "R11";
    addr_pins = 2'b11;
    start_idle(); write_byte(8'h74, 1'b1); stop();
    start_idle(); write_byte(8'h76, 1'b0); stop();

    // R10: broadcast reload, reset, unknown command
    cur_req = "R10";
    start_idle(); write_byte(8'h00, 1'b1); write_byte(8'h04, 1'b1); stop();
    check("R10 no reset on reload", gc_seen, 0);
    cur_req = "R11";
    start_idle(); write_byte(8'h76, 1'b1); stop();
    start_idle(); write_byte(8'h74, 1'b0); stop();
    cur_req = "R10";
    start_idle(); write_byte(8'h00, 1'b1); write_byte(8'h06, 1'b1); stop();
    check("R10 reset pulse count", gc_seen, 1);
    start_idle(); write_byte(8'h00, 1'b1); write_byte(8'h55, 1'b0); stop();
    check("R10 no pulse on unknown command", gc_seen, 1);

    wait_n(10);
    check("R3 all written bytes delivered", rx_exp.size(), 0);
    check("R6 all tx bytes taken", tx_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule